// File: doc/BRIEF.md
# Programmable Watchdog Timer with Prescaler

This block is a supervisory timer that asks the reset generator for a chip reset when software stops servicing it. A 15-bit up-counter advances on ticks from a fixed divider of the system clock. An extra divide-by-16 stage can be switched into that tick path. Each time the timer is loaded, its upper 7 bits come from a software reload value and its lower 8 bits are cleared. The time-out therefore runs from a short setting up to the full 15-bit range, and the extra stage stretches it by a further factor of 16.

The timer starts in one of two ways. A pin can be sampled when reset is released, or software can issue a start command. Once running, nothing but the external reset stops it. Software keeps it alive with a two-step service sequence: an arm write, then a kick on the write that directly follows. When the counter passes its top value, the block raises a one-cycle reset request. It also sets a sticky cause flag, which survives the reset it requested so that software can tell why the chip restarted.

Top module: `wdt_top`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `rstReq` and `statusFlag` are 0. Without a start, the timer stays idle and never requests a reset.
- R2: A `kickWr` pulse while the timer is idle starts it. No arm is needed. The counter loads reload bits 6:0 into its upper 7 bits, clears its lower 8 bits, and counts upward.
- R3: If `startPin` is 1 at the first rising edge after `rstN` goes high, the timer starts at that edge, using the reload value 0x00 that reset leaves behind.
- R4: Counting from the load edge, `rstReq` rises after (128 − bits 6:0) × 256 × BASE_DIV clock edges. The count is multiplied by 16 when reload bit 7 is 1.
- R5: Reload bits 7:0 are captured only at a load (start, service or overflow). A `relWr` changes only later loads. A load on the same edge as a `relWr` uses the previous value.
- R6: A write is any cycle in which `armWr`, `kickWr`, `relWr` or `statusClr` is high. While the timer is running, an `armWr` followed by a `kickWr` on the next write reloads the timer, however many idle cycles lie between them.
- R7: A `kickWr` while running has no effect unless the previous write was an arm alone. Three cases are ignored: a kick without an arm, a kick after an intervening write, and an arm and kick in the same cycle.
- R8: Once running, the timer cannot be stopped by any input except `rstN`.
- R9: On overflow, `rstReq` is high for exactly one cycle and `statusFlag` is set in that same cycle. The counter then reloads from the captured value and keeps running.
- R10: `statusFlag` is cleared only by `rstN` or by a `statusClr` pulse. If an overflow and `statusClr` occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low external reset |
| startPin | input | 1 | Hardware start level, sampled at the first edge after reset |
| armWr | input | 1 | Write that sets the service-arm bit |
| kickWr | input | 1 | Write that sets the start/service bit |
| relWr | input | 1 | Write strobe for the reload register |
| relData | input | 8 | Reload value: bit 7 selects the divide-by-16 stage, bits 6:0 give the upper count |
| statusClr | input | 1 | Software clear of the cause flag |
| rstReq | output | 1 | One-cycle reset request on overflow |
| statusFlag | output | 1 | Sticky flag recording that the watchdog caused a reset |

## Verification
The hardest case to reach from the ports is an overflow landing on the same edge as a software clear of the flag. The stimulus holds `statusClr` high for a window longer than one whole period, so an overflow is certain to fall inside it, and the reference model predicts the edge. The ordering rules are also hard to reach. They are covered by placing bare kicks, arm–write–kick runs and simultaneous arm-kick writes late in a period, where any wrongly accepted service would visibly move the next reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the control side into the counting datapath
  typedef struct packed {
    logic load;   // start or service: reload counter, clear prescalers
    logic run;    // timer is running
  } wdtCtl_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPin,
  input  logic    armWr,
  input  logic    kickWr,
  input  logic    relWr,
  input  logic    statusClr,
  input  logic    wrapNow,
  output wdtCtl_t ctl,
  output logic    statusFlag
);
  logic running;
  logic armed;
  logic firstCyc;
  logic anyWr;
  logic startNow;
  logic serviceNow;

  assign anyWr      = armWr | kickWr | relWr | statusClr;
  assign startNow   = !running && (kickWr || (firstCyc && startPin));
  assign serviceNow = running && kickWr && armed && !armWr;

  always_comb begin
    ctl.load = startNow | serviceNow;
    ctl.run  = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      armed      <= 1'b0;
      firstCyc   <= 1'b1;
      statusFlag <= 1'b0;
    end else begin
      firstCyc <= 1'b0;
      if (startNow) running <= 1'b1;
      if (anyWr) armed <= armWr && !kickWr;
      if (wrapNow) statusFlag <= 1'b1;
      else if (statusClr) statusFlag <= 1'b0;
    end
  end

  // R8
  no_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusFlag) |-> $past(statusClr));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int LOW_W    = 8,
  parameter int HIGH_W   = 7,
  parameter int BASE_DIV = 2,
  parameter int EXT_DIV  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtCtl_t           ctl,
  input  logic              relWr,
  input  logic [HIGH_W:0]   relData,
  output logic              wrapNow,
  output logic              rstReq
);
  localparam int CNT_W = LOW_W + HIGH_W;
  localparam int PRE_W = $clog2(BASE_DIV + 1);
  localparam int EXT_W = $clog2(EXT_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_DIV - 1);
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_DIV - 1);

  logic [HIGH_W:0]   relReg;
  logic [HIGH_W-1:0] relHigh;
  logic              div16;
  logic [PRE_W-1:0]  preCnt;
  logic [EXT_W-1:0]  extCnt;
  logic [CNT_W-1:0]  cnt;
  logic              preWrap;
  logic              extWrap;
  logic              tick;

  assign preWrap = (preCnt == PRE_LAST);
  assign extWrap = (extCnt == EXT_LAST);
  assign tick    = preWrap && (!div16 || extWrap);
  assign wrapNow = ctl.run && !ctl.load && tick && (&cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) relReg <= '0;
    else if (relWr) relReg <= relData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relHigh <= '0;
      div16   <= 1'b0;
      preCnt  <= '0;
      extCnt  <= '0;
      cnt     <= '0;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= wrapNow;
      if (ctl.load) begin
        relHigh <= relReg[HIGH_W-1:0];
        div16   <= relReg[HIGH_W];
        preCnt  <= '0;
        extCnt  <= '0;
        cnt     <= {relReg[HIGH_W-1:0], {LOW_W{1'b0}}};
      end else if (ctl.run) begin
        preCnt <= preWrap ? '0 : preCnt + 1'b1;
        if (preWrap && div16) extCnt <= extWrap ? '0 : extCnt + 1'b1;
        if (tick) begin
          if (&cnt) cnt <= {relHigh, {LOW_W{1'b0}}};
          else      cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(ctl.run));
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int LOW_W    = 8,
  parameter int HIGH_W   = 7,
  parameter int BASE_DIV = 2,
  parameter int EXT_DIV  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPin,
  input  logic              armWr,
  input  logic              kickWr,
  input  logic              relWr,
  input  logic [HIGH_W:0]   relData,
  input  logic              statusClr,
  output logic              rstReq,
  output logic              statusFlag
);
  wdt_pkg::wdtCtl_t ctl;
  logic wrapNow;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPin(startPin), .armWr(armWr),
    .kickWr(kickWr), .relWr(relWr), .statusClr(statusClr),
    .wrapNow(wrapNow), .ctl(ctl), .statusFlag(statusFlag)
  );

  wdt_datapath #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .BASE_DIV(BASE_DIV),
                 .EXT_DIV(EXT_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .relWr(relWr), .relData(relData),
    .wrapNow(wrapNow), .rstReq(rstReq)
  );

  // R9
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> statusFlag);
endmodule

// File: tb/wdt_top_test.sv
module wdt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_DIV   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPin = 1'b0;
  logic armWr = 1'b0, kickWr = 1'b0, relWr = 1'b0, statusClr = 1'b0;
  logic [7:0] relData = 8'h00;
  logic rstReq, statusFlag;

  wdt_top uut (
    .clk(clk), .rstN(rstN), .startPin(startPin), .armWr(armWr),
    .kickWr(kickWr), .relWr(relWr), .relData(relData),
    .statusClr(statusClr), .rstReq(rstReq), .statusFlag(statusFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  string phaseReq = "R1";

  // behavioural reference state
  bit mRun, mArmed, mStatus, mRst, mFirst;
  int mRel;
  longint remaining, period;
  int rstSeen;

  function automatic longint periodOf(int rel);
    longint p;
    p = longint'(128 - (rel % 128)) * 256 * BASE_DIV;
    if (rel >= 128) p = p * 16;
    return p;
  endfunction

  task automatic compare();
    checks++;
    if (rstReq !== mRst || statusFlag !== mStatus) begin
      errors++;
      $display("FAIL %s: rstReq=%b statusFlag=%b expected rstReq=%b statusFlag=%b at %0t",
               phaseReq, rstReq, statusFlag, mRst, mStatus, $time);
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit k, input bit w, input int d, input bit c);
    bit anyWr, start, svc, load, wrap;
    armWr = a; kickWr = k; relWr = w; relData = d[7:0]; statusClr = c;
    @(posedge clk);
    anyWr = a | k | w | c;
    start = !mRun && (k || (mFirst && startPin));
    svc   = mRun && k && mArmed && !a;
    load  = start | svc;
    wrap  = 1'b0;
    if (load) begin
      period = periodOf(mRel);
      remaining = period;
    end else if (mRun) begin
      remaining--;
      if (remaining == 0) begin
        wrap = 1'b1;
        remaining = period;
      end
    end
    if (start) mRun = 1'b1;
    if (anyWr) mArmed = a && !k;
    mRst = wrap;
    if (wrap) mStatus = 1'b1;
    else if (c) mStatus = 1'b0;
    if (w) mRel = d;
    mFirst = 1'b0;
    @(negedge clk);
    if (rstReq === 1'b1) rstSeen++;
    compare();
    armWr = 0; kickWr = 0; relWr = 0; statusClr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic doReset(input bit pin);
    rstN = 1'b0;
    startPin = pin;
    repeat (3) @(negedge clk);
    mRun = 0; mArmed = 0; mStatus = 0; mRst = 0; mFirst = 1; mRel = 0;
    remaining = 0; period = 0;
    phaseReq = "R1";
    compare();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset(0);
    // R1: idle without start, arm alone does not start
    phaseReq = "R1";
    step(1, 0, 0, 0, 0);
    rstSeen = 0;
    idle(2000);
    check(rstSeen == 0, "R1", "requests while idle", rstSeen, 0);

    // R2/R4/R9: software start with reload 0x7E -> 1024 cycles
    phaseReq = "R2";
    step(0, 0, 1, 8'h7E, 0);
    step(0, 1, 0, 0, 0);
    phaseReq = "R4";
    rstSeen = 0;
    idle(1023);
    check(rstSeen == 0, "R4", "request before time-out", rstSeen, 0);
    phaseReq = "R9";
    idle(1);
    check(rstReq === 1'b1, "R9", "request at time-out", rstReq, 1);
    idle(1);
    check(statusFlag === 1'b1, "R9", "flag sticky", statusFlag, 1);
    idle(1100);
    check(rstSeen == 2, "R9", "continues after overflow", rstSeen, 2);

    // R6: proper service keeps it quiet
    phaseReq = "R6";
    rstSeen = 0;
    for (int i = 0; i < 5; i++) begin
      idle(600);
      step(1, 0, 0, 0, 0);
      idle(3);
      step(0, 1, 0, 0, 0);
    end
    idle(600);
    check(rstSeen == 0, "R6", "requests with service", rstSeen, 0);

    // R7: wrong orders ignored; R5: reload write only affects later loads
    phaseReq = "R7";
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 8'h7F, 0);
    step(0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    rstSeen = 0;
    idle(450);
    check(rstSeen == 1, "R7", "ignored service lets overflow through", rstSeen, 1);
    phaseReq = "R5";
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    rstSeen = 0;
    idle(1100);
    check(rstSeen == 2, "R5", "new reload gives 512-cycle period", rstSeen, 2);

    // R10/R8: clear held over an overflow; set wins; nothing stops it
    phaseReq = "R10";
    for (int i = 0; i < 700; i++) step(0, 0, 0, 0, 1);
    idle(20);
    phaseReq = "R8";
    rstSeen = 0;
    step(0, 0, 1, 8'h00, 1);
    idle(1100);
    check(rstSeen == 2, "R8", "still running", rstSeen, 2);

    // R4: divide-by-16 stage, reload 0xFF -> 8192 cycles
    phaseReq = "R4";
    step(0, 0, 1, 8'hFF, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    rstSeen = 0;
    idle(8191);
    check(rstSeen == 0, "R4", "prescaled early request", rstSeen, 0);
    idle(1);
    check(rstReq === 1'b1, "R4", "prescaled request", rstReq, 1);

    // R3: pin start at reset release, reload 0 -> 65536 cycles
    doReset(1);
    phaseReq = "R3";
    rstSeen = 0;
    idle(65535);
    check(rstSeen == 0, "R3", "early request", rstSeen, 0);
    idle(2);
    check(rstSeen == 1, "R3", "pin-started overflow", rstSeen, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule